// File: doc/BRIEF.md
# Smart Card Baud Divisor Calculator

This block converts the two rate indices that a smart card announces after reset into settings for the bit-timing generator. One index selects the clock-rate conversion factor F and the other selects the baud-rate adjustment factor D. The result is an 8-bit divisor and a flag that chooses between 12x and 8x oversampling. Both factors come from fixed lookup tables. D can be a fraction as small as 1/64, so the unit stores it scaled by 64 and divides 64*F by that scaled value. The result is the exact F/D ratio with no rounding.

A request is one `start_i` pulse with the two indices. A single shared restoring divider then works for several cycles. It first forms the ratio and then tests whether the ratio divides by twelve. The unit uses 12x oversampling whenever the ratio allows it and falls back to 8x otherwise. It rejects a ratio that is not whole, a ratio that is a multiple of neither 8 nor 12, and a divisor that does not fit in 8 bits. Each of these has its own error code. The `done_o` output pulses once with the error code. The settings registers take a new value only when the request succeeds, so the bit-timing generator never sees a partial or illegal setting.

Top module: `sc_baud_calc`

## Requirements
- R1: After reset `divisor_o` is 31, `sample12_o` is 1, and both `done_o` and `busy_o` are 0. These are the settings for F=372, D=1.
- R2: F by index 0..15 is {0,372,558,744,1116,1488,1860,0,0,512,768,1024,1536,2048,0,0}. D*64 by index 0..15 is {0,64,128,256,512,1024,0,0,0,0,32,16,8,4,2,1}. A zero entry in either table ends the request with error code 1 (bad index), and no division is performed.
- R3: When 64*F is not an exact multiple of 64*D, the request ends with error code 2 (fractional ratio).
- R4: When the ratio R=F/D is a multiple of 12, the result is `sample12_o`=1 with divisor R/12. This applies even when R is also a multiple of 8.
- R5: When R is not a multiple of 12 but is a multiple of 8, the result is `sample12_o`=0 with divisor R/8.
- R6: When R is a multiple of neither 8 nor 12, the request ends with error code 3.
- R7: When the chosen divisor exceeds 255, the request ends with error code 4.
- R8: `done_o` is high for exactly one cycle per accepted request, and `err_o` is valid in that cycle (0 = success). `busy_o` is high from the cycle after `start_i` is accepted until `done_o` rises.
- R9: A `start_i` pulse while `busy_o` is high is ignored. It produces no extra `done_o` and does not change the running result.
- R10: `divisor_o` and `sample12_o` change only in a `done_o` cycle whose `err_o` is 0. After any error they keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse, accepted when idle |
| fi_i | input | 4 | Clock-rate conversion index |
| di_i | input | 4 | Baud-rate adjustment index |
| busy_o | output | 1 | Calculation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 3 | Result code, valid with `done_o` |
| divisor_o | output | 8 | Bit-timing divisor setting |
| sample12_o | output | 1 | 1 = 12x oversampling, 0 = 8x |

## Verification
A wrong internal state shows up at the ports within one request. A bad table entry or a divider that misses a remainder gives the wrong `err_o` or the wrong divisor in the very next `done_o` cycle. A state machine that loses its place shows up as a missing, doubled or wide `done_o` pulse, which the scoreboard sees as an empty queue or an unanswered entry. Settings that are corrupted on an error path are caught at the next completion, because every result is compared against the value held since the last success. A full sweep of all 256 index pairs exercises every table entry and every error branch.

// File: rtl/sc_bd_pkg.sv
package sc_bd_pkg;

   typedef enum logic [2:0] {
      BD_OK       = 3'd0,
      BD_BAD_IDX  = 3'd1,
      BD_FRACTION = 3'd2,
      BD_NOT_MULT = 3'd3,
      BD_RANGE    = 3'd4
   } bd_err_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOOK,
      ST_RATIO,
      ST_SPLIT,
      ST_FIN
   } bd_state_e;

endpackage

// File: rtl/sc_bd_tables.sv
module sc_bd_tables #(
   parameter int IDX_W = 4,
   parameter int F_W   = 12,
   parameter int D_W   = 11
) (
   input  logic [IDX_W-1:0] fi_i,
   input  logic [IDX_W-1:0] di_i,
   output logic [F_W-1:0]   f_o,
   output logic [D_W-1:0]   d64_o,
   output logic             ok_o
);

   localparam int F_MAX = 2048;
   localparam int D_MAX = 1024;

   generate
      if (IDX_W != 4) begin : g_bad_idx
         $error("sc_bd_tables: index width must be 4");
      end
      if ((1 << F_W) <= F_MAX) begin : g_bad_f
         $error("sc_bd_tables: F_W too narrow for the F table");
      end
      if ((1 << D_W) <= D_MAX) begin : g_bad_d
         $error("sc_bd_tables: D_W too narrow for the scaled D table");
      end
   endgenerate

   function automatic int f_lookup(input logic [3:0] idx);
      case (idx)
         4'd1:    return 372;
         4'd2:    return 558;
         4'd3:    return 744;
         4'd4:    return 1116;
         4'd5:    return 1488;
         4'd6:    return 1860;
         4'd9:    return 512;
         4'd10:   return 768;
         4'd11:   return 1024;
         4'd12:   return 1536;
         4'd13:   return 2048;
         default: return 0;
      endcase
   endfunction

   function automatic int d64_lookup(input logic [3:0] idx);
      if (idx >= 4'd1 && idx <= 4'd5) return 32 << idx;
      if (idx >= 4'd10)               return 1 << (4'd15 - idx);
      return 0;
   endfunction

   always_comb begin
      f_o   = F_W'(f_lookup(fi_i[3:0]));
      d64_o = D_W'(d64_lookup(di_i[3:0]));
      ok_o  = (f_o != '0) && (d64_o != '0);
   end

endmodule

// File: rtl/sc_bd_restoring_div.sv
module sc_bd_restoring_div #(
   parameter int NW = 18,
   parameter int DW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go_i,
   input  logic [NW-1:0] num_i,
   input  logic [DW-1:0] den_i,
   output logic          done_o,
   output logic [NW-1:0] quo_o,
   output logic [DW-1:0] rem_o
);

   localparam int CW = $clog2(NW + 1);

   generate
      if (NW < 2 || DW < 2) begin : g_bad_w
         $error("sc_bd_restoring_div: operand widths too small");
      end
   endgenerate

   logic [NW-1:0] quo_q;
   logic [DW-1:0] rem_q;
   logic [DW-1:0] den_q;
   logic [CW-1:0] cnt_q;
   logic          busy_q;
   logic          done_q;
   logic [DW:0]   shifted;
   logic [DW+1:0] trial;

   always_comb begin
      shifted = {rem_q, quo_q[NW-1]};
      trial   = {1'b0, shifted} - {2'b00, den_q};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quo_q  <= '0;
         rem_q  <= '0;
         den_q  <= '0;
         cnt_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (go_i && !busy_q) begin
            quo_q  <= num_i;
            rem_q  <= '0;
            den_q  <= den_i;
            cnt_q  <= CW'(NW);
            busy_q <= 1'b1;
         end else if (busy_q) begin
            if (!trial[DW+1]) begin
               rem_q <= trial[DW-1:0];
               quo_q <= {quo_q[NW-2:0], 1'b1};
            end else begin
               rem_q <= shifted[DW-1:0];
               quo_q <= {quo_q[NW-2:0], 1'b0};
            end
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign done_o = done_q;
   assign quo_o  = quo_q;
   assign rem_o  = rem_q;

endmodule

// File: rtl/sc_bd_split.sv
module sc_bd_split
   import sc_bd_pkg::*;
#(
   parameter int NW    = 18,
   parameter int DIV_W = 8
) (
   input  logic [NW-1:0]    ratio_i,
   input  logic [NW-1:0]    q12_i,
   input  logic             r12_zero_i,
   output logic [DIV_W-1:0] div_o,
   output logic             s12_o,
   output bd_err_e          code_o
);

   localparam logic [NW-1:0] DIV_MAX = NW'((1 << DIV_W) - 1);

   logic [NW-1:0] cand;

   always_comb begin
      cand   = '0;
      s12_o  = 1'b0;
      code_o = BD_OK;
      if (r12_zero_i) begin
         cand  = q12_i;
         s12_o = 1'b1;
      end else if (ratio_i[2:0] == 3'b000) begin
         cand  = ratio_i >> 3;
         s12_o = 1'b0;
      end else begin
         code_o = BD_NOT_MULT;
      end
      if (code_o == BD_OK && cand > DIV_MAX) begin
         code_o = BD_RANGE;
      end
      div_o = cand[DIV_W-1:0];
   end

endmodule

// File: rtl/sc_baud_calc.sv
module sc_baud_calc
   import sc_bd_pkg::*;
#(
   parameter int IDX_W   = 4,
   parameter int F_W     = 12,
   parameter int D_W     = 11,
   parameter int SCALE_SH = 6,
   parameter int DIV_W   = 8,
   parameter int RST_DIV = 31,
   parameter bit RST_S12 = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [IDX_W-1:0] fi_i,
   input  logic [IDX_W-1:0] di_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [2:0]       err_o,
   output logic [DIV_W-1:0] divisor_o,
   output logic             sample12_o
);

   localparam int NUM_W = F_W + SCALE_SH;
   localparam logic [D_W-1:0] TWELVE = D_W'(12);

   generate
      if (RST_DIV >= (1 << DIV_W)) begin : g_bad_rst
         $error("sc_baud_calc: reset divisor does not fit DIV_W");
      end
      if (D_W < 4) begin : g_bad_dw
         $error("sc_baud_calc: D_W must hold the constant 12");
      end
   endgenerate

   bd_state_e        state_q;
   logic [IDX_W-1:0] fi_q, di_q;
   logic [NUM_W-1:0] ratio_q;
   bd_err_e          code_q;
   logic [DIV_W-1:0] res_div_q;
   logic             res_s12_q;

   logic [F_W-1:0]   f_val;
   logic [D_W-1:0]   d64_val;
   logic             tab_ok;

   logic             div_go;
   logic [NUM_W-1:0] div_num;
   logic [D_W-1:0]   div_den;
   logic             div_done;
   logic [NUM_W-1:0] div_quo;
   logic [D_W-1:0]   div_rem;

   logic [DIV_W-1:0] sp_div;
   logic             sp_s12;
   bd_err_e          sp_code;

   sc_bd_tables #(
      .IDX_W (IDX_W),
      .F_W   (F_W),
      .D_W   (D_W)
   ) u_tables (
      .fi_i  (fi_q),
      .di_i  (di_q),
      .f_o   (f_val),
      .d64_o (d64_val),
      .ok_o  (tab_ok)
   );

   always_comb begin
      div_go  = 1'b0;
      div_num = ratio_q;
      div_den = TWELVE;
      if (state_q == ST_LOOK && tab_ok) begin
         div_go  = 1'b1;
         div_num = {f_val, {SCALE_SH{1'b0}}};
         div_den = d64_val;
      end else if (state_q == ST_RATIO && div_done && div_rem == '0) begin
         div_go  = 1'b1;
         div_num = div_quo;
         div_den = TWELVE;
      end
   end

   sc_bd_restoring_div #(
      .NW (NUM_W),
      .DW (D_W)
   ) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .go_i   (div_go),
      .num_i  (div_num),
      .den_i  (div_den),
      .done_o (div_done),
      .quo_o  (div_quo),
      .rem_o  (div_rem)
   );

   sc_bd_split #(
      .NW    (NUM_W),
      .DIV_W (DIV_W)
   ) u_split (
      .ratio_i    (ratio_q),
      .q12_i      (div_quo),
      .r12_zero_i (div_rem == '0),
      .div_o      (sp_div),
      .s12_o      (sp_s12),
      .code_o     (sp_code)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         fi_q       <= '0;
         di_q       <= '0;
         ratio_q    <= '0;
         code_q     <= BD_OK;
         res_div_q  <= '0;
         res_s12_q  <= 1'b0;
         done_o     <= 1'b0;
         err_o      <= 3'd0;
         divisor_o  <= DIV_W'(RST_DIV);
         sample12_o <= RST_S12;
      end else begin
         done_o <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  fi_q    <= fi_i;
                  di_q    <= di_i;
                  state_q <= ST_LOOK;
               end
            end
            ST_LOOK: begin
               if (tab_ok) begin
                  state_q <= ST_RATIO;
               end else begin
                  code_q  <= BD_BAD_IDX;
                  state_q <= ST_FIN;
               end
            end
            ST_RATIO: begin
               if (div_done) begin
                  ratio_q <= div_quo;
                  if (div_rem != '0) begin
                     code_q  <= BD_FRACTION;
                     state_q <= ST_FIN;
                  end else begin
                     state_q <= ST_SPLIT;
                  end
               end
            end
            ST_SPLIT: begin
               if (div_done) begin
                  code_q    <= sp_code;
                  res_div_q <= sp_div;
                  res_s12_q <= sp_s12;
                  state_q   <= ST_FIN;
               end
            end
            ST_FIN: begin
               done_o <= 1'b1;
               err_o  <= code_q;
               if (code_q == BD_OK) begin
                  divisor_o  <= res_div_q;
                  sample12_o <= res_s12_q;
               end
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o = (state_q != ST_IDLE);

endmodule

// File: rtl/sc_baud_calc_chk.sv
module sc_baud_calc_chk #(
   parameter int DIV_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             busy_o,
   input logic             done_o,
   input logic [2:0]       err_o,
   input logic [DIV_W-1:0] divisor_o,
   input logic             sample12_o
);

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R8
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(busy_o));

   // R9
   idle_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o);

   // R10
   hold_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && err_o != 3'd0) |-> ($stable(divisor_o) && $stable(sample12_o)));

   // R10
   change_only_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(divisor_o) || !$stable(sample12_o)) |-> (done_o && err_o == 3'd0));

   // R4
   ok_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && err_o == 3'd0) |-> (divisor_o != '0));

   // R2
   err_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (err_o <= 3'd4));

endmodule

bind sc_baud_calc sc_baud_calc_chk #(.DIV_W(DIV_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .err_o      (err_o),
   .divisor_o  (divisor_o),
   .sample12_o (sample12_o)
);

// File: tb/sc_baud_calc_tb.sv
module sc_baud_calc_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [3:0] fi_i = '0;
   logic [3:0] di_i = '0;
   logic       busy_o, done_o, sample12_o;
   logic [2:0] err_o;
   logic [7:0] divisor_o;

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   typedef struct {
      logic [2:0] err;
      logic [7:0] div;
      logic       s12;
      string      req;
   } exp_t;

   exp_t sb_q[$];
   logic [7:0] held_div = 8'd31;
   logic       held_s12 = 1'b1;

   always #2.5 clk = ~clk;

   sc_baud_calc u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .fi_i       (fi_i),
      .di_i       (di_i),
      .busy_o     (busy_o),
      .done_o     (done_o),
      .err_o      (err_o),
      .divisor_o  (divisor_o),
      .sample12_o (sample12_o)
   );

   function automatic int tb_f(input int i);
      int t[16] = '{0,372,558,744,1116,1488,1860,0,0,512,768,1024,1536,2048,0,0};
      return t[i];
   endfunction

   function automatic int tb_d(input int i);
      int t[16] = '{0,64,128,256,512,1024,0,0,0,0,32,16,8,4,2,1};
      return t[i];
   endfunction

   // Spec model: returns code; updates div/s12 only on success
   function automatic int tb_model(input int fi, input int di,
                                   inout logic [7:0] dv, inout logic s);
      int f, d, num, r, c, s12;
      f = tb_f(fi);
      d = tb_d(di);
      if (f == 0 || d == 0) return 1;
      num = 64 * f;
      if (num % d != 0) return 2;
      r = num / d;
      if (r % 12 == 0) begin c = r / 12; s12 = 1; end
      else if (r % 8 == 0) begin c = r / 8; s12 = 0; end
      else return 3;
      if (c > 255) return 4;
      dv = 8'(c);
      s  = 1'(s12);
      return 0;
   endfunction

   function automatic string tag_of(input int code, input logic s);
      case (code)
         1: return "R2";
         2: return "R3";
         3: return "R6";
         4: return "R7";
         default: return s ? "R4" : "R5";
      endcase
   endfunction

   task automatic check(input string req, input int act, input int exp, input string what);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic issue(input int fi, input int di, input string req);
      exp_t e;
      int code;
      while (busy_o) @(negedge clk);
      code  = tb_model(fi, di, held_div, held_s12);
      e.err = 3'(code);
      e.div = held_div;
      e.s12 = held_s12;
      e.req = (req == "") ? tag_of(code, held_s12) : req;
      sb_q.push_back(e);
      fi_i    = 4'(fi);
      di_i    = 4'(di);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   // Scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && done_o) begin
         exp_t e;
         if (sb_q.size() == 0) begin
            n_vec++;
            n_bad++;
            $display("FAIL R8 unexpected done: actual 1 expected 0");
         end else begin
            e = sb_q.pop_front();
            check(e.req, int'(err_o), int'(e.err), "err");
            check(e.req, int'(divisor_o), int'(e.div), "divisor");
            check(e.req, int'(sample12_o), int'(e.s12), "sample12");
         end
      end
   end

   task automatic drain();
      while (busy_o || sb_q.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", int'(divisor_o), 31, "divisor");
      check("R1", int'(sample12_o), 1, "sample12");
      check("R1", int'(done_o), 0, "done");
      check("R1", int'(busy_o), 0, "busy");
      rst_n = 1'b1;
      @(negedge clk);

      issue(1, 1, "R4");     // default: 372 -> 31, 12x
      issue(9, 1, "R5");     // 512 -> 64, 8x
      issue(0, 1, "R2");     // F index 0
      issue(1, 0, "R2");     // D index 0
      issue(7, 7, "R2");     // reserved pair
      issue(1, 5, "R3");     // 23808/1024
      issue(2, 1, "R6");     // 558
      issue(1, 13, "R7");    // 496 > 255
      issue(11, 12, "R10");  // 8192/12 no, /8 = 1024 -> range, hold
      issue(1, 12, "R4");    // 2976 -> 248
      drain();

      // R8 busy after accept, one-cycle done; R9 start while busy ignored
      issue(9, 2, "R9");     // 256 -> 32, 8x
      check("R8", int'(busy_o), 1, "busy after start");
      fi_i = 4'd0; di_i = 4'd0; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      while (!done_o) @(negedge clk);
      @(negedge clk);
      check("R8", int'(done_o), 0, "done width");
      drain();
      check("R9", int'(divisor_o), 32, "divisor after ignored start");

      for (int fi = 0; fi < 16; fi++) begin
         for (int di = 0; di < 16; di++) begin
            issue(fi, di, "");
         end
      end
      drain();
      report();
   end

endmodule